// File: doc/BRIEF.md
# Extended Hamming SECDED Codec for 4-bit Words

This block protects a 4-bit data word with an extended Hamming code. It adds three check bits and one overall parity bit to make an 8-bit codeword. The encoder channel turns a data nibble into a codeword. The decoder channel takes a received 8-bit word and returns the data, the 3-bit syndrome and a one-hot status:

- clean word,
- corrected data-bit error,
- hit on a check bit only,
- uncorrectable double error.

The check bits sit at the power-of-two Hamming positions. Because of this, a nonzero syndrome is the position of the bit in error. A flip is applied only when the overall parity check also fails.

Each channel is a valid/ready stream with a single output register. A word is accepted on a rising clock edge when `*_in_valid` and `*_in_ready` are both high. Its result appears with `*_out_valid` after that edge. `*_in_ready` is high whenever the output register is empty or its result is being taken in the same cycle (`*_out_ready` high). While `*_out_valid` is high and `*_out_ready` is low, the result holds steady and no new word is accepted. When no word is accepted and the consumer is ready, `*_out_valid` falls. The producer must hold its word and valid until they are accepted.

Top module: `secded_codec`

## Requirements
- R1: Codeword bits [6:0] hold, from bit 6 down to bit 0: d4, d3, d2, c3, d1, c2, c1. Data input bit 0 is d1 and bit 3 is d4. The check bits are c1 = d1^d2^d4, c2 = d1^d3^d4 and c3 = d2^d3^d4. Hamming position n is codeword bit n-1.
- R2: Codeword bit 7 is the overall parity bit, chosen so that all 8 codeword bits have an even number of ones.
- R3: A received word with even overall parity and zero syndrome returns its data bits unchanged, with the clean flag set and syndrome 0.
- R4: A single flipped bit at Hamming position 3, 5, 6 or 7 makes the syndrome equal to that position. The matching data bit (d1, d2, d3 or d4) is flipped back, and the fixed flag is set.
- R5: A single flipped bit at Hamming position 1, 2 or 4 makes the syndrome equal to that position. The check-error flag is set and the data passes through unchanged.
- R6: A flipped overall parity bit (bit 7) gives syndrome 0 with the check-error flag set, and the data passes through unchanged.
- R7: Even overall parity with a nonzero syndrome sets the double flag. The syndrome shown is the XOR of the two error positions (bit 7 counts as 0), and the data is the raw received bits {bit6, bit5, bit4, bit2} with no flip.
- R8: Whenever a decoder result is valid, exactly one of the clean, fixed, check-error and double flags is high.
- R9: After reset both output valids are low. A word accepted on an edge is presented with its output valid after that same edge. The output valid falls after the next edge on which no word is accepted and the output is ready.
- R10: While an output is valid and its ready is low, the output data holds, `*_in_ready` is low, and an offered word is not accepted until ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Encoder data word offered |
| enc_in_ready | output | 1 | Encoder can accept a word this cycle |
| enc_in_data | input | 4 | Data nibble, bit 0 = d1 |
| enc_out_valid | output | 1 | Codeword valid |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_code | output | 8 | Codeword with overall parity in bit 7 |
| dec_in_valid | input | 1 | Received word offered |
| dec_in_ready | output | 1 | Decoder can accept a word this cycle |
| dec_in_word | input | 8 | Received 8-bit word |
| dec_out_valid | output | 1 | Decoder result valid |
| dec_out_ready | input | 1 | Consumer takes the decoder result |
| dec_out_data | output | 4 | Corrected or raw data nibble |
| dec_out_syndrome | output | 3 | Position of the faulty Hamming bit, 0 if none |
| dec_out_clean | output | 1 | No error found |
| dec_out_fixed | output | 1 | Single data-bit error corrected |
| dec_out_chkerr | output | 1 | Single error in a check or parity bit only |
| dec_out_double | output | 1 | Uncorrectable double error |

## Verification
The encoder is checked against all 16 nibbles, and those codewords are fed straight back into the decoder. This confirms the bit layout and shows that clean words never raise a flag. Single flips are then applied at each of the eight bit positions. These flips separate data repair from check-bit hits and from an overall-parity hit: the same syndrome value 0 must mean clean in one case and check-error in the other. Paired flips, including pairs with the parity bit, show that a nonzero syndrome with even parity leaves the data raw. A stalled-consumer sequence shows the output holds, and that the word offered during the stall is taken only when ready returns.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 4;
  localparam int CHK_W  = 3;
  localparam int HAM_W  = (1 << CHK_W) - 1;
  localparam int CODE_W = HAM_W + 1;
  localparam int SYN_W  = CHK_W;
  localparam int FLAG_W = 4;
  localparam int DRES_W = FLAG_W + SYN_W + DATA_W;

  typedef struct packed {
    logic clean;
    logic fixed;
    logic chkerr;
    logic dbl;
  } dec_flags_t;

  // Hamming position (1-based) of data bit i: the i-th non-power-of-two position
  function automatic int data_pos(input int i);
    int n;
    int res;
    n = 0;
    res = 0;
    for (int p = 1; p <= HAM_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) res = p;
        n++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic [HAM_W-1:0] ham;

  always_comb begin
    ham = '0;
    for (int i = 0; i < DATA_W; i++) ham[data_pos(i)-1] = data[i];
    for (int k = 0; k < CHK_W; k++) begin
      for (int p = 1; p <= HAM_W; p++) begin
        if (p != (1 << k) && ((p >> k) & 1) == 1)
          ham[(1 << k) - 1] = ham[(1 << k) - 1] ^ ham[p-1];
      end
    end
  end

  assign code = {^ham, ham};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CODE_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic [SYN_W-1:0]  syn,
  output dec_flags_t        flags
);
  logic par_err;
  logic syn_nz;
  logic chk_pos;

  always_comb begin
    syn = '0;
    for (int k = 0; k < CHK_W; k++) begin
      for (int p = 1; p <= HAM_W; p++) begin
        if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ word[p-1];
      end
    end
  end

  assign par_err = ^word;
  assign syn_nz  = |syn;
  assign chk_pos = $onehot0(syn);

  assign flags.clean  = !par_err && !syn_nz;
  assign flags.dbl    = !par_err && syn_nz;
  assign flags.chkerr = par_err && chk_pos;
  assign flags.fixed  = par_err && !chk_pos;

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int POS = data_pos(i);
    assign data[i] = word[POS-1] ^ (flags.fixed && (syn == SYN_W'(POS)));
  end
endmodule

// File: rtl/secded_stage.sv
module secded_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_in_valid,
  output logic              enc_in_ready,
  input  logic [DATA_W-1:0] enc_in_data,
  output logic              enc_out_valid,
  input  logic              enc_out_ready,
  output logic [CODE_W-1:0] enc_out_code,
  input  logic              dec_in_valid,
  output logic              dec_in_ready,
  input  logic [CODE_W-1:0] dec_in_word,
  output logic              dec_out_valid,
  input  logic              dec_out_ready,
  output logic [DATA_W-1:0] dec_out_data,
  output logic [SYN_W-1:0]  dec_out_syndrome,
  output logic              dec_out_clean,
  output logic              dec_out_fixed,
  output logic              dec_out_chkerr,
  output logic              dec_out_double
);
  logic [CODE_W-1:0] enc_code_c;
  logic [DATA_W-1:0] dec_data_c;
  logic [SYN_W-1:0]  dec_syn_c;
  dec_flags_t        dec_flags_c;
  dec_flags_t        dec_flags_q;
  logic [DRES_W-1:0] dec_res_q;

  secded_enc u_enc (.data(enc_in_data), .code(enc_code_c));

  secded_stage #(.W(CODE_W)) u_enc_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_data(enc_code_c),
    .out_valid(enc_out_valid), .out_ready(enc_out_ready), .out_data(enc_out_code)
  );

  secded_dec u_dec (.word(dec_in_word), .data(dec_data_c), .syn(dec_syn_c), .flags(dec_flags_c));

  secded_stage #(.W(DRES_W)) u_dec_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_in_valid), .in_ready(dec_in_ready),
    .in_data({dec_flags_c, dec_syn_c, dec_data_c}),
    .out_valid(dec_out_valid), .out_ready(dec_out_ready), .out_data(dec_res_q)
  );

  assign {dec_flags_q, dec_out_syndrome, dec_out_data} = dec_res_q;
  assign dec_out_clean  = dec_flags_q.clean;
  assign dec_out_fixed  = dec_flags_q.fixed;
  assign dec_out_chkerr = dec_flags_q.chkerr;
  assign dec_out_double = dec_flags_q.dbl;

  p_even_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid |-> (^enc_out_code == 1'b0));
  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> $onehot({dec_out_clean, dec_out_fixed, dec_out_chkerr, dec_out_double}));
  p_clean_syn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_out_clean) |-> (dec_out_syndrome == '0));
  p_double_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_in_valid && dec_in_ready && !(^dec_in_word) && dec_syn_c != '0) |=>
    (dec_out_double && dec_out_data == $past({dec_in_word[6:4], dec_in_word[2]})));
endmodule

// File: tb/secded_codec_test.sv
`timescale 1ns/1ps
module secded_codec_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_in_valid = 1'b0, enc_in_ready, enc_out_valid, enc_out_ready = 1'b1;
  logic [3:0] enc_in_data = '0;
  logic [7:0] enc_out_code;
  logic       dec_in_valid = 1'b0, dec_in_ready, dec_out_valid, dec_out_ready = 1'b1;
  logic [7:0] dec_in_word = '0;
  logic [3:0] dec_out_data;
  logic [2:0] dec_out_syndrome;
  logic       dec_out_clean, dec_out_fixed, dec_out_chkerr, dec_out_double;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  secded_codec uut (.*);

  localparam logic [3:0] F_CLEAN = 4'b1000, F_FIXED = 4'b0100, F_CHK = 4'b0010, F_DBL = 4'b0001;

  function automatic logic [7:0] ref_code(input logic [3:0] d);
    logic c1, c2, c3;
    logic [6:0] h;
    c1 = d[0] ^ d[1] ^ d[3];
    c2 = d[0] ^ d[2] ^ d[3];
    c3 = d[1] ^ d[2] ^ d[3];
    h = {d[3], d[2], d[1], c3, d[0], c2, c1};
    return {^h, h};
  endfunction

  function automatic logic [2:0] pos_of(input int idx);
    return (idx == 7) ? 3'd0 : 3'(idx + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_dec(input logic [7:0] w);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_word = w;
    @(negedge clk);
    dec_in_valid = 1'b0;
  endtask

  task automatic check_dec(input string req, input logic [3:0] d, input logic [2:0] s, input logic [3:0] f);
    check({req, " valid"}, 32'(dec_out_valid), 32'd1);
    check({req, " data"}, 32'(dec_out_data), 32'(d));
    check({req, " syndrome"}, 32'(dec_out_syndrome), 32'(s));
    check({"R8 ", req, " flags"},
          32'({dec_out_clean, dec_out_fixed, dec_out_chkerr, dec_out_double}), 32'(f));
  endtask

  task automatic t_reset;
    check("R9 reset enc valid", 32'(enc_out_valid), 32'd0);
    check("R9 reset dec valid", 32'(dec_out_valid), 32'd0);
  endtask

  task automatic t_encode_all;
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      enc_in_valid = 1'b1;
      enc_in_data = 4'(v);
      @(negedge clk);
      enc_in_valid = 1'b0;
      check("R1 encode layout", 32'(enc_out_code[6:0]), 32'(ref_code(4'(v)) & 8'h7F));
      check("R2 overall parity even", 32'(^enc_out_code), 32'd0);
    end
  endtask

  task automatic t_clean_all;
    for (int v = 0; v < 16; v++) begin
      send_dec(ref_code(4'(v)));
      check_dec("R3 clean", 4'(v), 3'd0, F_CLEAN);
    end
  endtask

  task automatic t_single_data;
    logic [3:0] pats [2] = '{4'hA, 4'h5};
    int idxs [4] = '{2, 4, 5, 6};
    foreach (pats[a]) begin
      foreach (idxs[b]) begin
        send_dec(ref_code(pats[a]) ^ (8'd1 << idxs[b]));
        check_dec("R4 data fix", pats[a], pos_of(idxs[b]), F_FIXED);
      end
    end
  endtask

  task automatic t_single_check;
    logic [3:0] pats [2] = '{4'hC, 4'h3};
    int idxs [3] = '{0, 1, 3};
    foreach (pats[a]) begin
      foreach (idxs[b]) begin
        send_dec(ref_code(pats[a]) ^ (8'd1 << idxs[b]));
        check_dec("R5 check hit", pats[a], pos_of(idxs[b]), F_CHK);
      end
    end
  endtask

  task automatic t_overall;
    send_dec(ref_code(4'h9) ^ 8'h80);
    check_dec("R6 overall bit", 4'h9, 3'd0, F_CHK);
    send_dec(ref_code(4'h0) ^ 8'h80);
    check_dec("R6 overall bit zero", 4'h0, 3'd0, F_CHK);
  endtask

  task automatic t_double;
    int pa [5] = '{0, 2, 3, 4, 6};
    int pb [5] = '{1, 6, 7, 5, 2};
    logic [7:0] w;
    for (int n = 0; n < 5; n++) begin
      w = ref_code(4'h6) ^ (8'd1 << pa[n]) ^ (8'd1 << pb[n]);
      send_dec(w);
      check_dec("R7 double", {w[6], w[5], w[4], w[2]}, pos_of(pa[n]) ^ pos_of(pb[n]), F_DBL);
    end
  endtask

  task automatic t_latency;
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_word = ref_code(4'hB);
    check("R9 not yet valid", 32'(dec_out_valid), 32'd0);
    @(negedge clk);
    dec_in_valid = 1'b0;
    check("R9 valid after one edge", 32'(dec_out_valid), 32'd1);
    check("R9 data after one edge", 32'(dec_out_data), 32'hB);
    @(negedge clk);
    check("R9 valid drops", 32'(dec_out_valid), 32'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    dec_out_ready = 1'b0;
    dec_in_valid = 1'b1;
    dec_in_word = ref_code(4'h1);
    @(negedge clk);
    check("R10 first taken", 32'(dec_out_data), 32'h1);
    check("R10 in_ready low", 32'(dec_in_ready), 32'd0);
    dec_in_word = ref_code(4'hE);
    @(negedge clk);
    check("R10 held valid", 32'(dec_out_valid), 32'd1);
    check("R10 held data", 32'(dec_out_data), 32'h1);
    @(negedge clk);
    check("R10 still held", 32'(dec_out_data), 32'h1);
    dec_out_ready = 1'b1;
    @(negedge clk);
    dec_in_valid = 1'b0;
    check("R10 second taken", 32'(dec_out_data), 32'hE);
    check("R10 second valid", 32'(dec_out_valid), 32'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encode_all();
    t_clean_all();
    t_single_data();
    t_single_check();
    t_overall();
    t_double();
    t_latency();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule